// File: doc/BRIEF.md
# Two-Digit Decimal Stopwatch Counter

This block keeps a decimal count from 00 to 99 and advances it by one on each rising clock edge while `go` is high. With `go` low the count stays where it is. A synchronous `clear` returns the count to 00 and wins over `go` when both are high in the same cycle. After 99 the count wraps to 00. Every clock edge is one tick. There is no prescaler, so any slower time base has to come from outside the block.

The count is built from two mod-10 digit counters. The units counter is enabled by `go`. It raises a terminal pulse only when it holds 9 and is enabled, and that pulse enables the tens counter. Both digits therefore step together on the 9-to-0 wrap of the units digit. Each digit is output as a 4-bit BCD value and also goes through its own seven-segment decoder.

The block uses an asynchronous active-low reset. Inside the block, the release of that reset is synchronised to the clock.

Top module: `stopwatch_bcd`

## Requirements
- R1: After reset, both BCD outputs are 0 and both segment outputs show the pattern for 0.
- R2: When `clear` is 1 at a rising edge, both digits are 0 after that edge.
- R3: When `clear` and `go` are both 1 at the same edge, the result is 00. Clear takes priority over counting.
- R4: When `go` is 1 and `clear` is 0, the units digit goes up by one at each edge while it is below 9, and the tens digit keeps its value. Starting from 00, the first such edge gives 01.
- R5: When `go` is 0 and `clear` is 0, both digits keep their values across the edge.
- R6: When the units digit is 9 and the count is enabled, the next edge sets the units digit to 0 and raises the tens digit by one, in that same edge.
- R7: At count 99, an enabled edge gives 00. From 00, 100 enabled edges in a row give 00 again.
- R8: Each BCD output stays in the range 0 to 9 at all times.
- R9: Segment outputs are active-high, with bit 6 down to bit 0 driving segments g,f,e,d,c,b,a. The patterns for digits 0 to 9 are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F, 0x6F. A code above 9 blanks the display (0x00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock. The count changes on rising edges. |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronised inside the block. |
| clear | input | 1 | Synchronous return to 00. Overrides `go`. |
| go | input | 1 | 1 = count, 0 = hold. |
| units_bcd | output | 4 | Units digit in BCD. |
| tens_bcd | output | 4 | Tens digit in BCD. |
| units_seg | output | 7 | Units digit segments {g,f,e,d,c,b,a}, active-high. |
| tens_seg | output | 7 | Tens digit segments {g,f,e,d,c,b,a}, active-high. |

## Verification
A long unbroken run with `go` high passes through both the 99-to-00 wrap and every 9-to-0 units wrap. This run tells a correct cascade apart from one where the tens digit steps early, steps late, or stays still. Short bursts separated by pauses show whether holding really freezes both digits, including a pause that starts exactly at a units value of 9. A `go` that toggles every cycle gives alternate count and hold edges, which catches a tens enable left active after the terminal value has passed. Clear is applied mid-count with `go` both high and low, which confirms that clear wins over counting.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int DIGIT_W    = 4;
  localparam int RADIX      = 10;
  localparam int NUM_DIGITS = 2;
  localparam int SEG_W      = 7;
  localparam int SYNC_DEPTH = 2;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [SEG_W-1:0]   seg_t;
endpackage

// File: rtl/stopwatch_rst_sync.sv
module stopwatch_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [DEPTH-1:0] stage_q;
  logic [DEPTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[DEPTH-1];
endmodule

// File: rtl/stopwatch_digit.sv
module stopwatch_digit #(
  parameter int WIDTH   = 4,
  parameter int MODULUS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  output logic [WIDTH-1:0] q,
  output logic             term
);
  localparam logic [WIDTH-1:0] LAST = WIDTH'(MODULUS - 1);

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == LAST);

  // next-state: clear first, then enable
  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + WIDTH'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign q    = cnt_q;
  assign term = en & at_last;
endmodule

// File: rtl/stopwatch_seg7.sv
module stopwatch_seg7
  import stopwatch_pkg::*;
(
  input  digit_t code,
  output seg_t   seg
);
  // active-high, bit order {g,f,e,d,c,b,a}
  always_comb begin
    unique case (code)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/stopwatch_bcd.sv
module stopwatch_bcd
  import stopwatch_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       go,
  output logic [3:0] units_bcd,
  output logic [3:0] tens_bcd,
  output logic [6:0] units_seg,
  output logic [6:0] tens_seg
);
  logic                  rst_core_n;
  logic [NUM_DIGITS:0]   enable_chain;
  digit_t                digit_val [NUM_DIGITS];
  seg_t                  digit_seg [NUM_DIGITS];
  logic                  wrap_all;

  stopwatch_rst_sync #(.DEPTH(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  assign enable_chain[0] = go;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    stopwatch_digit #(.WIDTH(DIGIT_W), .MODULUS(RADIX)) u_cnt (
      .clk   (clk),
      .rst_n (rst_core_n),
      .clr   (clear),
      .en    (enable_chain[i]),
      .q     (digit_val[i]),
      .term  (enable_chain[i+1])
    );

    stopwatch_seg7 u_dec (
      .code (digit_val[i]),
      .seg  (digit_seg[i])
    );
  end

  // full-range rollover; observed by the bound checker
  assign wrap_all = enable_chain[NUM_DIGITS];

  assign units_bcd = digit_val[0];
  assign tens_bcd  = digit_val[1];
  assign units_seg = digit_seg[0];
  assign tens_seg  = digit_seg[1];
endmodule

// File: rtl/stopwatch_bcd_chk.sv
module stopwatch_bcd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic       go,
  input logic       wrap_all,
  input logic [3:0] units,
  input logic [3:0] tens,
  input logic [6:0] units_seg,
  input logic [6:0] tens_seg
);
  // R2 R3
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (units == 4'd0 && tens == 4'd0));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !go) |=> ($stable(units) && $stable(tens)));

  // R4
  units_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && go && units != 4'd9) |=>
      (units == $past(units) + 4'd1 && $stable(tens)));

  // R6
  carry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && go && units == 4'd9 && tens != 4'd9) |=>
      (units == 4'd0 && tens == $past(tens) + 4'd1));

  // R7
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && wrap_all) |=> (units == 4'd0 && tens == 4'd0));

  // R8
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (units <= 4'd9 && tens <= 4'd9));

  // R9
  segs_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (units_seg != 7'h00 && tens_seg != 7'h00));
endmodule

bind stopwatch_bcd stopwatch_bcd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .clear     (clear),
  .go        (go),
  .wrap_all  (wrap_all),
  .units     (units_bcd),
  .tens      (tens_bcd),
  .units_seg (units_seg),
  .tens_seg  (tens_seg)
);

// File: tb/stopwatch_bcd_tb.sv
module stopwatch_bcd_tb;
  logic       clk;
  logic       rst_n;
  logic       clear;
  logic       go;
  logic [3:0] units_bcd;
  logic [3:0] tens_bcd;
  logic [6:0] units_seg;
  logic [6:0] tens_seg;

  int tests  = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  stopwatch_bcd u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .go        (go),
    .units_bcd (units_bcd),
    .tens_bcd  (tens_bcd),
    .units_seg (units_seg),
    .tens_seg  (tens_seg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [6:0] seg_of(input int d);
    case (d)
      0: return 7'h3F;
      1: return 7'h06;
      2: return 7'h5B;
      3: return 7'h4F;
      4: return 7'h66;
      5: return 7'h6D;
      6: return 7'h7D;
      7: return 7'h07;
      8: return 7'h7F;
      9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check_all(input string tag);
    int eu, et;
    eu = model % 10;
    et = model / 10;
    tests++;
    if (units_bcd !== 4'(eu) || tens_bcd !== 4'(et)) begin
      errors++;
      $display("FAIL %s: count %0d%0d, expected %0d%0d", tag, tens_bcd, units_bcd, et, eu);
    end
    tests++;
    if (units_bcd > 4'd9 || tens_bcd > 4'd9) begin
      errors++;
      $display("FAIL R8: digits %0d/%0d, expected both <= 9", tens_bcd, units_bcd);
    end
    tests++;
    if (units_seg !== seg_of(eu) || tens_seg !== seg_of(et)) begin
      errors++;
      $display("FAIL R9: segs %h/%h, expected %h/%h", tens_seg, units_seg, seg_of(et), seg_of(eu));
    end
  endtask

  // drive on the falling edge, update the model, check at the next falling edge
  task automatic tick(input logic c, input logic g);
    string tag;
    if (c && g)              tag = "R3";
    else if (c)              tag = "R2";
    else if (!g)             tag = "R5";
    else if (model == 99)    tag = "R7";
    else if (model % 10 == 9) tag = "R6";
    else                     tag = "R4";
    clear = c;
    go    = g;
    if (c)      model = 0;
    else if (g) model = (model + 1) % 100;
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear = 1'b0;
    go    = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    check_all("R1");

    // R4: first enabled edge gives 01
    tick(1'b0, 1'b1);
    for (int i = 0; i < 13; i++) tick(1'b0, 1'b1);
    // R5: pause mid-count
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0);
    // count up to x9 and pause there (R5 at units 9)
    while (model % 10 != 9) tick(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0);
    tick(1'b0, 1'b1); // R6
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b1);
    // R3: clear with go high mid-count
    tick(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) tick(1'b0, 1'b1);
    // R2: clear with go low
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    // R7: 100 enabled edges from 00 return to 00, then a second pass
    for (int i = 0; i < 100; i++) tick(1'b0, 1'b1);
    tests++;
    if (units_bcd !== 4'd0 || tens_bcd !== 4'd0) begin
      errors++;
      $display("FAIL R7: after 100 ticks %0d%0d, expected 00", tens_bcd, units_bcd);
    end
    for (int i = 0; i < 130; i++) tick(1'b0, 1'b1);
    // alternating go
    for (int i = 0; i < 60; i++) tick(1'b0, 1'(i % 2));
    // irregular go pattern
    for (int i = 0; i < 90; i++) tick(1'b0, 1'((i % 3) != 0));
    // clear exactly at 99 with go high
    while (model != 99) tick(1'b0, 1'b1);
    tick(1'b1, 1'b1);
    tick(1'b0, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, errors);
    $finish;
  end
endmodule